// File: doc/BRIEF.md
# Bus-Driven Integer Coprocessor Port

This block is the slave end of an arithmetic coprocessor that hangs off a host bus. The host never issues a dedicated coprocessor command: it only performs ordinary write and read transactions, and a 7-bit side-band modifier field that travels with each transaction tells the block what the transaction means. A write loads operand A, operand B or the opcode register. A single write carries a full 64-bit operand: the address lines supply the upper 32 bits and the data lines supply the lower 32 bits. An operand write may also set a go bit, so the last operand arrives and the operation starts in the same cycle.

The execution unit is integer only: a 64-bit add, a 64-bit multiply that keeps the low half of the product, a multiply-accumulate into an internal 64-bit accumulator, and an accumulator clear. Each has a fixed latency. The opcode register keeps its value, so a run of go-flagged operand writes repeats the same operation without rewriting the opcode. Results come back as two 32-bit reads, low half then high half. Any read of this unit, and any go-flagged write, that arrives while an operation runs is held with `stall` until the operation has finished.

A three-state controller sequences the work. EMPTY (no result since reset) moves to RUN on a launch. RUN counts the latency down and moves to READY when the count expires. READY moves back to RUN on the next launch. A launch is an accepted go-flagged operand write.

Top module: `copro_xact_if`

## Requirements
- R1: A selected write with `mod[1:0]`=0 loads operand A and with `mod[1:0]`=1 loads operand B. The 64-bit value is `{addr, data}`, so `addr` is the upper half.
- R2: A selected write with `mod[1:0]`=2 loads the opcode from `data[1:0]`: 0 is add, 1 is multiply, 2 is multiply-accumulate, 3 is clear accumulator. The opcode is kept until the next opcode write.
- R3: An operand write with the go bit `mod[2]`=1 starts the current opcode on operands that include the value written in that same cycle. The go bit on an opcode write starts nothing.
- R4: A selected read returns result bits 31:0 when `mod[0]`=0 and bits 63:32 when `mod[0]`=1. While an operation runs, the read is stalled and `stall` is high.
- R5: A read issued in the cycle after a launch stalls for exactly the operation's latency: 5 cycles for add, 6 for multiply, 6 for multiply-accumulate, 1 for clear.
- R6: Add returns A+B modulo 2^64.
- R7: Multiply returns the low 64 bits of A*B.
- R8: Multiply-accumulate adds the low 64 bits of A*B to the accumulator and returns the new accumulator value. It can be reissued by go-flagged operand writes alone.
- R9: Clear accumulator sets the accumulator and the result to zero.
- R10: A go-flagged operand write that arrives during an operation is stalled and is neither stored nor launched until the running operation finishes.
- R11: Writes with `mod[1:0]`=3, and any transaction whose `mod[6:3]` differs from the unit select (default 5), change nothing and never stall.
- R12: After reset, `stall` is low and both result halves read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_req | input | 1 | Write transaction request |
| rd_req | input | 1 | Read transaction request |
| mod | input | 7 | Side-band modifier: [6:3] unit select, [2] go bit, [1:0] write kind; [0] selects the result half on reads |
| addr | input | 32 | Address lines, upper operand half on writes |
| data | input | 32 | Data lines, lower operand half or opcode on writes |
| stall | output | 1 | Holds the host while a read or go-write must wait |
| rdata | output | 32 | Selected 32-bit result half |

## Verification
The arithmetic is tried with operands that carry across the 32-bit boundary and overflow 64 bits, so a swapped address/data half or a lost carry gives a different sum or product. A run of go-flagged operand writes without any opcode write shows that the kept opcode is reissued and that the accumulator builds up. A launch for each opcode, with a read right behind it, measures the stall length per latency. A go-write during an operation, a reserved-kind write and transactions with another unit select show that held or foreign traffic neither stores nor launches anything.

// File: rtl/copro_pkg.sv
`timescale 1ns/1ps
package copro_pkg;

    typedef enum logic [1:0] {
        OPC_ADD = 2'd0,
        OPC_MUL = 2'd1,
        OPC_MAC = 2'd2,
        OPC_CLR = 2'd3
    } opc_t;

    typedef enum logic [1:0] {
        XK_OPA   = 2'd0,
        XK_OPB   = 2'd1,
        XK_INSTR = 2'd2,
        XK_RSVD  = 2'd3
    } xkind_t;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_RUN   = 2'd1,
        ST_READY = 2'd2
    } ctl_state_t;

endpackage

// File: rtl/copro_wr_decode.sv
`timescale 1ns/1ps
module copro_wr_decode
    import copro_pkg::*;
#(
    parameter int                 BUS_W    = 32,
    parameter int                 SEL_W    = 4,
    parameter logic [SEL_W-1:0]   UNIT_SEL = 4'h5,
    localparam int                MOD_W    = SEL_W + 3,
    localparam int                DW       = 2 * BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic             rd_req,
    input  logic [MOD_W-1:0] mod,
    input  logic [BUS_W-1:0] addr,
    input  logic [BUS_W-1:0] data,
    input  logic             busy,
    output logic             start_req,
    output logic             rd_hit,
    output logic [DW-1:0]    opa_nx,
    output logic [DW-1:0]    opb_nx,
    output opc_t             opc_nx
);

    logic          sel_hit;
    logic          go_bit;
    logic          wr_take;
    xkind_t        kind;
    logic [DW-1:0] opa_q;
    logic [DW-1:0] opb_q;
    opc_t          opc_q;

    assign sel_hit = (mod[MOD_W-1:3] == UNIT_SEL);
    assign go_bit  = mod[2];
    assign kind    = xkind_t'(mod[1:0]);

    // a go-flagged operand write is the only transaction that launches work
    assign start_req = wr_req && sel_hit && go_bit &&
                       ((kind == XK_OPA) || (kind == XK_OPB));
    assign rd_hit    = rd_req && sel_hit;

    // a held launch write must not land in the operand registers yet
    assign wr_take = wr_req && sel_hit && !(start_req && busy);

    always_comb begin
        opa_nx = opa_q;
        opb_nx = opb_q;
        opc_nx = opc_q;
        if (wr_take) begin
            unique case (kind)
                XK_OPA:   opa_nx = {addr, data};
                XK_OPB:   opb_nx = {addr, data};
                XK_INSTR: opc_nx = opc_t'(data[1:0]);
                XK_RSVD:  ;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opa_q <= '0;
            opb_q <= '0;
            opc_q <= OPC_ADD;
        end else begin
            opa_q <= opa_nx;
            opb_q <= opb_nx;
            opc_q <= opc_nx;
        end
    end

endmodule

// File: rtl/copro_seq_ctrl.sv
`timescale 1ns/1ps
module copro_seq_ctrl
    import copro_pkg::*;
#(
    parameter int LAT_ADD = 5,
    parameter int LAT_MUL = 6,
    parameter int LAT_MAC = 6,
    parameter int LAT_CLR = 1,
    localparam int MAX_AM  = (LAT_ADD > LAT_MUL) ? LAT_ADD : LAT_MUL,
    localparam int MAX_CC  = (LAT_MAC > LAT_CLR) ? LAT_MAC : LAT_CLR,
    localparam int MAX_LAT = (MAX_AM > MAX_CC) ? MAX_AM : MAX_CC,
    localparam int CNT_W   = $clog2(MAX_LAT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic rd_hit,
    input  opc_t opc,
    output logic stall,
    output logic launch,
    output logic finish,
    output logic busy,
    output logic res_valid
);

    ctl_state_t       state_q;
    ctl_state_t       state_d;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [CNT_W-1:0] lat_load(input opc_t o);
        logic [CNT_W-1:0] v;
        unique case (o)
            OPC_ADD: v = CNT_W'(LAT_ADD - 1);
            OPC_MUL: v = CNT_W'(LAT_MUL - 1);
            OPC_MAC: v = CNT_W'(LAT_MAC - 1);
            OPC_CLR: v = CNT_W'(LAT_CLR - 1);
            default: v = '0;
        endcase
        return v;
    endfunction

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (launch)        state_d = ST_RUN;
            ST_RUN:   if (cnt_q == '0)   state_d = ST_READY;
            ST_READY: if (launch)        state_d = ST_RUN;
            default:                     state_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        busy      = 1'b0;
        res_valid = 1'b0;
        unique case (state_q)
            ST_EMPTY: ;
            ST_RUN:   busy      = 1'b1;
            ST_READY: res_valid = 1'b1;
            default:  ;
        endcase
        launch = start_req && !busy;
        finish = busy && (cnt_q == '0);
        stall  = busy && (rd_hit || start_req);
    end

    // latency counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (launch)                 cnt_q <= lat_load(opc);
        else if (busy && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

endmodule

// File: rtl/copro_exec_unit.sv
`timescale 1ns/1ps
module copro_exec_unit
    import copro_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic          finish,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  opc_t          opc,
    output logic [DW-1:0] result
);

    logic [DW-1:0] snap_a;
    logic [DW-1:0] snap_b;
    opc_t          snap_op;
    logic [DW-1:0] acc_q;
    logic [DW-1:0] prod;
    logic [DW-1:0] acc_sum;

    assign prod    = snap_a * snap_b;
    assign acc_sum = acc_q + prod;

    // operands and opcode are frozen at launch so later writes cannot disturb a run
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_a  <= '0;
            snap_b  <= '0;
            snap_op <= OPC_ADD;
        end else if (launch) begin
            snap_a  <= opa;
            snap_b  <= opb;
            snap_op <= opc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
            acc_q  <= '0;
        end else if (finish) begin
            unique case (snap_op)
                OPC_ADD: result <= snap_a + snap_b;
                OPC_MUL: result <= prod;
                OPC_MAC: begin
                    acc_q  <= acc_sum;
                    result <= acc_sum;
                end
                OPC_CLR: begin
                    acc_q  <= '0;
                    result <= '0;
                end
                default: result <= result;
            endcase
        end
    end

endmodule

// File: rtl/copro_xact_if.sv
`timescale 1ns/1ps
module copro_xact_if
    import copro_pkg::*;
#(
    parameter int               BUS_W    = 32,
    parameter int               SEL_W    = 4,
    parameter logic [SEL_W-1:0] UNIT_SEL = 4'h5,
    parameter int               LAT_ADD  = 5,
    parameter int               LAT_MUL  = 6,
    parameter int               LAT_MAC  = 6,
    parameter int               LAT_CLR  = 1,
    localparam int              MOD_W    = SEL_W + 3,
    localparam int              DW       = 2 * BUS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic             rd_req,
    input  logic [MOD_W-1:0] mod,
    input  logic [BUS_W-1:0] addr,
    input  logic [BUS_W-1:0] data,
    output logic             stall,
    output logic [BUS_W-1:0] rdata
);

    logic          start_req;
    logic          rd_hit;
    logic          launch;
    logic          finish;
    logic          busy;
    logic          res_valid;
    logic [DW-1:0] opa_nx;
    logic [DW-1:0] opb_nx;
    opc_t          opc_nx;
    logic [DW-1:0] result;

    copro_wr_decode #(
        .BUS_W    (BUS_W),
        .SEL_W    (SEL_W),
        .UNIT_SEL (UNIT_SEL)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (wr_req),
        .rd_req    (rd_req),
        .mod       (mod),
        .addr      (addr),
        .data      (data),
        .busy      (busy),
        .start_req (start_req),
        .rd_hit    (rd_hit),
        .opa_nx    (opa_nx),
        .opb_nx    (opb_nx),
        .opc_nx    (opc_nx)
    );

    copro_seq_ctrl #(
        .LAT_ADD (LAT_ADD),
        .LAT_MUL (LAT_MUL),
        .LAT_MAC (LAT_MAC),
        .LAT_CLR (LAT_CLR)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .rd_hit    (rd_hit),
        .opc       (opc_nx),
        .stall     (stall),
        .launch    (launch),
        .finish    (finish),
        .busy      (busy),
        .res_valid (res_valid)
    );

    copro_exec_unit #(
        .DW (DW)
    ) u_exec (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch),
        .finish (finish),
        .opa    (opa_nx),
        .opb    (opb_nx),
        .opc    (opc_nx),
        .result (result)
    );

    // low half first, high half second, chosen by the lowest modifier bit
    assign rdata = mod[0] ? result[DW-1:BUS_W] : result[BUS_W-1:0];

endmodule

// File: rtl/copro_xact_sva.sv
`timescale 1ns/1ps
module copro_xact_sva #(
    parameter int DW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_hit,
    input logic          start_req,
    input logic          stall,
    input logic          busy,
    input logic          res_valid,
    input logic          launch,
    input logic [DW-1:0] result
);

    // R4: a stall only ever comes from a running operation
    assert_stall_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> busy);

    // R4: a read of this unit during a run is held
    assert_read_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && busy) |-> stall);

    // R10: a launch request during a run is held
    assert_go_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && busy) |-> stall);

    // R3: an accepted launch enters the run state with the old result invalidated
    assert_launch_runs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (busy && !res_valid));

    // R5: a run never coexists with a valid result
    assert_run_excl_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && res_valid));

    // R5: a run always ends with a valid result
    assert_run_ends_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> res_valid);

    // R5: the result register does not move in the middle of a run
    assert_result_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> $stable(result));

endmodule

bind copro_xact_if copro_xact_sva #(.DW(DW)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_hit    (rd_hit),
    .start_req (start_req),
    .stall     (stall),
    .busy      (busy),
    .res_valid (res_valid),
    .launch    (launch),
    .result    (result)
);

// File: tb/copro_xact_if_tb.sv
`timescale 1ns/1ps
module copro_xact_if_tb;

    localparam logic [3:0] SEL   = 4'h5;
    localparam logic [3:0] OTHER = 4'h2;

    logic        clk;
    logic        rst_n;
    logic        wr_req;
    logic        rd_req;
    logic [6:0]  mod;
    logic [31:0] addr;
    logic [31:0] data;
    logic        stall;
    logic [31:0] rdata;

    int n_tests;
    int n_fail;

    copro_xact_if u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_req (wr_req),
        .rd_req (rd_req),
        .mod    (mod),
        .addr   (addr),
        .data   (data),
        .stall  (stall),
        .rdata  (rdata)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // write transaction; counts cycles spent in stall
    task automatic wr(input logic [3:0] sel, input logic [1:0] kind, input logic go,
                      input logic [63:0] val, output int stalls);
        @(negedge clk);
        wr_req = 1'b1;
        mod    = {sel, go, kind};
        addr   = val[63:32];
        data   = val[31:0];
        stalls = 0;
        #1;
        while (stall) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        wr_req = 1'b0;
        mod    = '0;
    endtask

    task automatic rd(input logic [3:0] sel, input logic half,
                      output logic [31:0] v, output int stalls);
        @(negedge clk);
        rd_req = 1'b1;
        mod    = {sel, 2'b00, half};
        stalls = 0;
        #1;
        while (stall) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        v = rdata;
        @(posedge clk);
        #1;
        rd_req = 1'b0;
        mod    = '0;
    endtask

    task automatic rd64(output logic [63:0] v, output int stalls);
        logic [31:0] lo;
        logic [31:0] hi;
        int          s2;
        rd(SEL, 1'b0, lo, stalls);
        rd(SEL, 1'b1, hi, s2);
        v = {hi, lo};
    endtask

    task automatic t_reset();
        logic [31:0] v;
        int s;
        check("R12", "stall after reset", {63'd0, stall}, 64'd0);
        rd(SEL, 1'b0, v, s);
        check("R12", "low half after reset", {32'd0, v}, 64'd0);
        rd(SEL, 1'b1, v, s);
        check("R12", "high half after reset", {32'd0, v}, 64'd0);
        check("R12", "reset read stalls", s, 0);
    endtask

    task automatic t_add();
        logic [63:0] r;
        int s;
        wr(SEL, 2'd2, 1'b0, 64'd0, s);                       // opcode add, R2
        wr(SEL, 2'd0, 1'b0, 64'hFFFF_FFFF_0000_0001, s);     // R1
        wr(SEL, 2'd1, 1'b1, 64'h0000_0001_FFFF_FFFF, s);     // R3
        check("R3", "go write when idle stalls", s, 0);
        rd64(r, s);
        check("R5", "add stall cycles", s, 5);
        check("R6", "add carries across halves and wraps", r, 64'h0000_0001_0000_0000);
        check("R4", "high half word", {32'd0, r[63:32]}, 64'd1);
    endtask

    task automatic t_mul();
        logic [63:0] r;
        int s;
        wr(SEL, 2'd2, 1'b0, 64'd1, s);
        wr(SEL, 2'd0, 1'b0, 64'h0000_0001_0000_0003, s);
        wr(SEL, 2'd1, 1'b1, 64'd5, s);
        rd64(r, s);
        check("R5", "mul stall cycles", s, 6);
        check("R7", "mul product", r, 64'h0000_0005_0000_000F);
        wr(SEL, 2'd0, 1'b0, 64'h0000_0001_0000_0000, s);
        wr(SEL, 2'd1, 1'b1, 64'h0000_0001_0000_0000, s);
        rd64(r, s);
        check("R7", "mul keeps low 64 bits", r, 64'd0);
    endtask

    task automatic t_mac();
        logic [63:0] r;
        int s;
        wr(SEL, 2'd2, 1'b0, 64'd3, s);                       // clear
        wr(SEL, 2'd0, 1'b1, 64'd3, s);
        rd64(r, s);
        check("R5", "clear stall cycles", s, 1);
        check("R9", "clear result", r, 64'd0);
        wr(SEL, 2'd2, 1'b0, 64'd2, s);                       // mac
        wr(SEL, 2'd1, 1'b1, 64'd4, s);
        rd64(r, s);
        check("R5", "mac stall cycles", s, 6);
        check("R8", "first mac", r, 64'd12);
        wr(SEL, 2'd1, 1'b1, 64'd10, s);                      // opcode reused
        rd64(r, s);
        check("R8", "mac reissued by operand write", r, 64'd42);
        wr(SEL, 2'd2, 1'b1, 64'd2, s);                       // go on opcode write
        rd64(r, s);
        check("R3", "go on opcode write starts nothing", s, 0);
        check("R3", "result kept after opcode go", r, 64'd42);
    endtask

    task automatic t_busy();
        logic [63:0] r;
        int s;
        wr(SEL, 2'd2, 1'b0, 64'd0, s);
        wr(SEL, 2'd0, 1'b0, 64'd10, s);
        wr(SEL, 2'd1, 1'b1, 64'd20, s);
        wr(SEL, 2'd1, 1'b1, 64'd5, s);
        check("R10", "go write held during run", s, 5);
        rd64(r, s);
        check("R10", "held launch runs after release", s, 5);
        check("R10", "held write used after release", r, 64'd15);
    endtask

    task automatic t_ignore();
        logic [63:0] r;
        logic [31:0] v;
        int s;
        wr(SEL, 2'd3, 1'b1, 64'h0000_0000_0000_DEAD, s);
        check("R11", "reserved kind stalls", s, 0);
        rd64(r, s);
        check("R11", "reserved kind launches nothing", s, 0);
        check("R11", "result after reserved kind", r, 64'd15);
        wr(OTHER, 2'd0, 1'b1, 64'd777, s);
        rd64(r, s);
        check("R11", "foreign select launches nothing", s, 0);
        wr(SEL, 2'd1, 1'b1, 64'd1, s);                       // add 10+1
        rd(OTHER, 1'b0, v, s);
        check("R11", "foreign read not stalled", s, 0);
        rd64(r, s);
        check("R4", "remaining stall after foreign read", s, 4);
        check("R1", "operand A untouched by ignored writes", r, 64'd11);
    endtask

    initial begin
        n_tests = 0;
        n_fail  = 0;
        rst_n   = 1'b0;
        wr_req  = 1'b0;
        rd_req  = 1'b0;
        mod     = '0;
        addr    = '0;
        data    = '0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_add();
        t_mul();
        t_mac();
        t_busy();
        t_ignore();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule